// File: doc/BRIEF.md
# Encoder Speed Window Counter

This block measures how fast a shaft turns by counting the velocity pulses that an upstream quadrature decoder emits during a fixed, programmable time window. A down-counting window timer is loaded from a reload register. While it runs, every single-cycle velocity strobe adds one to a running pulse count.

When the timer expires, several things happen on the same clock edge. The running count is latched into a capture register and cleared. The timer is reloaded. A one-cycle interrupt pulse is raised, and a sticky status flag is set. The flag stays set until software acknowledges it with a write-one-to-clear strobe.

A separate restart command reloads the timer and clears the count without capturing anything. Software uses it to begin a clean measurement window, for example after changing the reload value.

Top module: `enc_speed_window`

## Requirements
- R1: After a synchronous reset, the capture register, the running count, the interrupt and the status flag are zero, and the reload register and the timer are all ones.
- R2: When neither expiry nor restart applies, the timer decreases by exactly one on each clock edge.
- R3: On the edge where the timer reads zero and no restart is asserted, the capture register takes the running count and the timer takes the reload value. A window loaded with value L therefore lasts L+1 clock cycles.
- R4: The interrupt output is high for exactly the one cycle that follows each expiry edge.
- R5: The running count rises by one on each edge where the velocity strobe is high, and otherwise holds.
- R6: The status flag is set by each expiry and stays set until an acknowledge strobe. When an expiry and an acknowledge fall on the same edge, the flag stays set.
- R7: A velocity strobe on an expiry edge is counted into the new window, so the count reads 1 after that edge.
- R8: A restart strobe overrides everything else on its edge. The timer takes the reload value and the count becomes zero, even when a velocity strobe is also present. The capture register is unchanged and no interrupt is raised, including on an edge where the timer reads zero.
- R9: A reload write updates the reload readback on the next edge. It does not alter the running timer, which picks up the new value only at its next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vel_pulse | input | 1 | Single-cycle velocity strobe from the decoder |
| reload_we | input | 1 | Reload register write strobe |
| reload_wdata | input | W | Reload value to write |
| restart | input | 1 | Restart strobe: reload timer, clear count, no capture |
| flag_ack | input | 1 | Write-one-to-clear acknowledge for the status flag |
| reload_val | output | W | Reload register readback |
| timer_val | output | W | Live window timer |
| pulse_cnt | output | W | Live pulse count of the current window |
| capture_val | output | W | Count from the last completed window |
| win_irq | output | 1 | One-cycle window-done interrupt |
| win_flag | output | 1 | Sticky window-done status |

## Verification
Every output is a register, so each result of a strobe appears one clock edge later and is checked a short delay after that edge. The exception is expiry, which lands L+1 edges after the load of a value L. The bench loads a small reload value, counts edges from the restart edge, and checks the capture register, the count, the timer and the interrupt right after the predicted expiry edge. It checks the interrupt once more an edge later to confirm that it has dropped. The same-edge collisions are each driven on exactly that predicted edge: a strobe with expiry, a restart with expiry, and an acknowledge with expiry.

// File: rtl/enc_speed_window.sv
module enc_speed_window #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vel_pulse,
  input  logic         reload_we,
  input  logic [W-1:0] reload_wdata,
  input  logic         restart,
  input  logic         flag_ack,
  output logic [W-1:0] reload_val,
  output logic [W-1:0] timer_val,
  output logic [W-1:0] pulse_cnt,
  output logic [W-1:0] capture_val,
  output logic         win_irq,
  output logic         win_flag
);
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic expire;
  assign expire = (timer_val == '0) && !restart;

  always_ff @(posedge clk) begin
    if (rst) reload_val <= ONES;
    else if (reload_we) reload_val <= reload_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)                      timer_val <= ONES;
    else if (restart || expire)   timer_val <= reload_val;
    else                          timer_val <= timer_val - ONE;
  end

  always_ff @(posedge clk) begin
    if (rst || restart)  pulse_cnt <= '0;
    else if (expire)     pulse_cnt <= vel_pulse ? ONE : '0;
    else if (vel_pulse)  pulse_cnt <= pulse_cnt + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)         capture_val <= '0;
    else if (expire) capture_val <= pulse_cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_irq  <= 1'b0;
      win_flag <= 1'b0;
    end else begin
      win_irq  <= expire;
      win_flag <= expire | (win_flag & ~flag_ack);
    end
  end
endmodule

module enc_speed_window_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         vel_pulse,
  input logic         restart,
  input logic         flag_ack,
  input logic [W-1:0] reload_val,
  input logic [W-1:0] timer_val,
  input logic [W-1:0] pulse_cnt,
  input logic [W-1:0] capture_val,
  input logic         win_irq,
  input logic         win_flag
);
  assert_timer_step_R2: assert property (@(posedge clk) disable iff (rst)
    (timer_val != '0 && !restart) |=> timer_val == $past(timer_val) - W'(1));

  assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (timer_val == '0 && !restart) |=>
      (capture_val == $past(pulse_cnt) && timer_val == $past(reload_val)));

  assert_irq_on_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    (timer_val == '0 && !restart) |=> win_irq);

  assert_irq_only_expiry_R4: assert property (@(posedge clk) disable iff (rst)
    (timer_val != '0 || restart) |=> !win_irq);

  assert_flag_follows_irq_R6: assert property (@(posedge clk) disable iff (rst)
    win_irq |-> win_flag);

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (win_flag && !flag_ack) |=> win_flag);

  assert_new_window_R7: assert property (@(posedge clk) disable iff (rst)
    (timer_val == '0 && !restart && vel_pulse) |=> pulse_cnt == W'(1));

  assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (pulse_cnt == '0 && !win_irq && $stable(capture_val)
                 && timer_val == $past(reload_val)));
endmodule

bind enc_speed_window enc_speed_window_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .vel_pulse(vel_pulse), .restart(restart),
  .flag_ack(flag_ack), .reload_val(reload_val), .timer_val(timer_val),
  .pulse_cnt(pulse_cnt), .capture_val(capture_val), .win_irq(win_irq),
  .win_flag(win_flag)
);

// File: tb/sim_enc_speed_window.sv
module sim_enc_speed_window;
  localparam int W = 32;
  logic clk = 0, rst = 1, vel_pulse = 0, reload_we = 0, restart = 0, flag_ack = 0;
  logic [W-1:0] reload_wdata = '0;
  logic [W-1:0] reload_val, timer_val, pulse_cnt, capture_val;
  logic win_irq, win_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  enc_speed_window #(.W(W)) u0 (
    .clk(clk), .rst(rst), .vel_pulse(vel_pulse), .reload_we(reload_we),
    .reload_wdata(reload_wdata), .restart(restart), .flag_ack(flag_ack),
    .reload_val(reload_val), .timer_val(timer_val), .pulse_cnt(pulse_cnt),
    .capture_val(capture_val), .win_irq(win_irq), .win_flag(win_flag)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic r, input logic a);
    vel_pulse = p; restart = r; flag_ack = a;
    @(posedge clk); #2;
    vel_pulse = 0; restart = 0; flag_ack = 0;
  endtask

  task automatic write_reload(input logic [W-1:0] v);
    reload_we = 1; reload_wdata = v;
    @(posedge clk); #2;
    reload_we = 0;
  endtask

  task automatic t_reset;
    chk("R1 timer", timer_val, '1);
    chk("R1 reload", reload_val, '1);
    chk("R1 count", pulse_cnt, '0);
    chk("R1 capture", capture_val, '0);
    chk("R1 irq", W'(win_irq), '0);
    chk("R1 flag", W'(win_flag), '0);
  endtask

  task automatic t_step_and_reload;
    logic [W-1:0] t0;
    t0 = timer_val;
    cyc(0, 0, 0);
    chk("R2 decrement", timer_val, t0 - 1);
    write_reload(W'(5));
    chk("R9 readback", reload_val, W'(5));
    chk("R9 timer untouched", timer_val, t0 - 2);
  endtask

  task automatic t_window;
    cyc(0, 1, 0);
    chk("R8 restart load", timer_val, W'(5));
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0); cyc(1, 0, 0);
    chk("R5 count", pulse_cnt, W'(3));
    chk("R2 timer", timer_val, W'(1));
    cyc(0, 0, 0);
    chk("R3 before expiry", W'(win_irq), '0);
    cyc(0, 0, 0);
    chk("R3 capture", capture_val, W'(3));
    chk("R3 count cleared", pulse_cnt, '0);
    chk("R3 reload", timer_val, W'(5));
    chk("R4 irq", W'(win_irq), W'(1));
    chk("R6 flag set", W'(win_flag), W'(1));
    cyc(0, 0, 0);
    chk("R4 irq drops", W'(win_irq), '0);
    chk("R6 flag sticky", W'(win_flag), W'(1));
    cyc(0, 0, 1);
    chk("R6 ack clears", W'(win_flag), '0);
  endtask

  task automatic t_pulse_at_expiry;
    cyc(0, 1, 0);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0);
    chk("R7 timer at zero", timer_val, '0);
    cyc(1, 0, 1);
    chk("R7 capture zero", capture_val, '0);
    chk("R7 new count", pulse_cnt, W'(1));
    chk("R6 set beats ack", W'(win_flag), W'(1));
    cyc(0, 0, 1);
  endtask

  task automatic t_restart_priority;
    write_reload(W'(3));
    chk("R9 timer keeps old window", timer_val, W'(3));
    cyc(0, 1, 0);
    chk("R9 new reload used", timer_val, W'(3));
    cyc(1, 0, 0); cyc(1, 0, 0); cyc(0, 0, 0);
    chk("R8 setup zero", timer_val, '0);
    cyc(1, 1, 0);
    chk("R8 capture kept", capture_val, '0);
    chk("R8 count cleared", pulse_cnt, '0);
    chk("R8 no irq", W'(win_irq), '0);
    chk("R8 no flag", W'(win_flag), '0);
    chk("R8 timer reload", timer_val, W'(3));
    cyc(1, 0, 0); cyc(0, 0, 0);
    cyc(1, 1, 0);
    chk("R8 mid-window restart", pulse_cnt, '0);
    chk("R8 mid-window capture kept", capture_val, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 0;
    t_reset();
    t_step_and_reload();
    t_window();
    t_pulse_at_expiry();
    t_restart_priority();
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule